// File: doc/BRIEF.md
# GPIO Interrupt Summary and End-of-Service Controller

This block sits between a large array of GPIO pins and one parent interrupt input. It takes each pin's pending flag and folds groups of four neighbouring pins into one summary bit. With the default 184 pins this gives 46 summary bits. Software reads the summary through two 32-bit status words. It uses them to find which group of four pins needs service, then scans only those pins.

The parent line is a level that rises when any summary bit is set and the line is armed. Once the parent controller takes the interrupt, the line drops and stays low. It comes back only when software writes the end-of-service bit in the master control word.

The master word also holds a status-blanking enable and a 12-bit length. While blanking is enabled, a write to any pin's debounce settings opens a blanking window that lasts that many clock cycles. During the window:
- the pin logic is told to generate no interrupt or wake status;
- every pin's interrupt-enable bit reads back as zero.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n is set exactly when at least one of the pending flags of pins 4n, 4n+1, 4n+2 and 4n+3 is set; it follows the flags combinationally.
- R2: Reading address 0 returns summary bits 31..0 at data bits 31..0. Reading address 1 returns summary bits 45..32 at data bits 13..0, with data bits 31..14 always zero. Address 3 reads zero.
- R3: The parent interrupt output is high whenever the line is armed and at least one summary bit is set, and low whenever no summary bit is set.
- R4: If the parent interrupt is high in a cycle where the take input is high, the line disarms. The output is then low from the next cycle on, even while summary bits stay set.
- R5: A write to address 2 with data bit 16 set re-arms the line. From the next cycle, the output is high if any summary bit is set. If the output rises later, it rises as soon as a summary bit is set. When take and this write fall in the same cycle, the write wins.
- R6: At address 2, data bits 11..0 are the blanking length and data bit 12 is the blanking enable; both are written and read back. Bit 16 is the end-of-service bit, which holds no state and always reads 0. All other bits read 0.
- R7: If blanking is enabled when the debounce-write input is high, the blanking output is high for exactly as many following cycles as the programmed length (a length of 0 gives no window).
- R8: A debounce write during an open window restarts the window at the full programmed length.
- R9: With blanking disabled, a debounce write leaves the blanking output low.
- R10: While blanking is high, every bit of the interrupt-enable view is 0. Otherwise each view bit equals that pin's interrupt-enable input.
- R11: After reset the line is armed, blanking is disabled with length 0, and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_pend | input | NPINS | Per-pin pending flags |
| pin_ie | input | NPINS | Per-pin interrupt-enable bits from pin configuration |
| pin_ie_view | output | NPINS | Interrupt-enable bits as software reads them (zero while blanking) |
| dbnc_wr | input | 1 | Pulse: some pin's debounce fields were written |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 low status, 1 high status, 2 master) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_take | input | 1 | Parent controller has taken the interrupt |
| irq_out | output | 1 | Parent interrupt line |
| blank | output | 1 | Status generation blocked for all pins |

## Verification
A stuck or wrong armed flag shows at once on the parent line. The line either stays high through a take or fails to rise in the cycle after an end-of-service write while pending flags are set.

A faulty blanking counter shows on the blanking output and the enable view. A window that is one cycle short or long, or that is not restarted, appears within a few cycles of the debounce pulse.

A wrong summary fold or register mux shows as soon as a single pin is raised. Single pins at group edges, and at both status words, pin down which bit moved.

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NPINS   = 184,
  parameter int LEN_W   = 12,
  parameter int BEN_BIT = 12,
  parameter int EOI_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_pend,
  input  logic [NPINS-1:0] pin_ie,
  output logic [NPINS-1:0] pin_ie_view,
  input  logic             dbnc_wr,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             irq_take,
  output logic             irq_out,
  output logic             blank
);
  localparam int NSUM = (NPINS + 3) / 4;
  localparam int NPAD = NSUM * 4;

  logic [NPAD-1:0]  pend_pad;
  logic [NSUM-1:0]  sum;
  logic [63:0]      sum64;
  logic             armed;
  logic             blk_en;
  logic [LEN_W-1:0] blk_len;
  logic [LEN_W-1:0] blk_cnt;
  logic [31:0]      mst_rd;

  assign pend_pad = NPAD'(pin_pend);

  for (genvar n = 0; n < NSUM; n++) begin : g_sum
    assign sum[n] = |pend_pad[4*n +: 4];
  end

  assign sum64 = 64'(sum);

  wire mst_wr = reg_we && (reg_addr == 2'd2);
  wire eoi_wr = mst_wr && reg_wdata[EOI_BIT];

  assign irq_out     = armed && (|sum);
  assign blank       = (blk_cnt != '0);
  assign pin_ie_view = blank ? '0 : pin_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b1;
      blk_en  <= 1'b0;
      blk_len <= '0;
      blk_cnt <= '0;
    end else begin
      if (eoi_wr)
        armed <= 1'b1;
      else if (irq_out && irq_take)
        armed <= 1'b0;

      if (mst_wr) begin
        blk_en  <= reg_wdata[BEN_BIT];
        blk_len <= reg_wdata[LEN_W-1:0];
      end

      if (dbnc_wr && blk_en)
        blk_cnt <= blk_len;
      else if (blk_cnt != '0)
        blk_cnt <= blk_cnt - 1'b1;
    end
  end

  always_comb begin
    mst_rd = '0;
    mst_rd[LEN_W-1:0] = blk_len;
    mst_rd[BEN_BIT]   = blk_en;
    case (reg_addr)
      2'd0:    reg_rdata = sum64[31:0];
      2'd1:    reg_rdata = sum64[63:32];
      2'd2:    reg_rdata = mst_rd;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk #(
  parameter int NPINS   = 184,
  parameter int LEN_W   = 12,
  parameter int EOI_BIT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pend_any,
  input logic [NPINS-1:0] pin_ie_view,
  input logic             dbnc_wr,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             irq_take,
  input logic             irq_out,
  input logic             blank,
  input logic             blk_en,
  input logic [LEN_W-1:0] blk_len
);
  localparam int HIW = (NPINS + 3) / 4 - 32;

  wire eoi_wr = reg_we && (reg_addr == 2'd2) && reg_wdata[EOI_BIT];

  p_irq_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pend_any);

  p_take_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && irq_take && !eoi_wr |=> !irq_out);

  p_eoi_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> (irq_out || !pend_any));

  p_eoi_reads0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> !reg_rdata[EOI_BIT]);

  p_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> ((reg_rdata >> HIW) == 32'd0));

  p_blank_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbnc_wr && blk_en && (blk_len != '0) |=> blank);

  p_no_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !blank && !(dbnc_wr && blk_en) |=> !blank);

  p_ie_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (pin_ie_view == '0));
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(
  .NPINS(NPINS), .LEN_W(LEN_W), .EOI_BIT(EOI_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_any(|pin_pend), .pin_ie_view(pin_ie_view),
  .dbnc_wr(dbnc_wr), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_take(irq_take),
  .irq_out(irq_out), .blank(blank), .blk_en(blk_en), .blk_len(blk_len)
);

// File: tb/sim_gpio_irq_summary.sv
module sim_gpio_irq_summary;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_pend = '0;
  logic [NP-1:0] pin_ie = '1;
  logic [NP-1:0] pin_ie_view;
  logic          dbnc_wr = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_take = 1'b0;
  logic          irq_out;
  logic          blank;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio_irq_summary u0 (
    .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .pin_ie(pin_ie),
    .pin_ie_view(pin_ie_view), .dbnc_wr(dbnc_wr), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_take(irq_take), .irq_out(irq_out), .blank(blank)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr_master(input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic dbnc_pulse();
    @(negedge clk);
    dbnc_wr = 1'b1;
    @(negedge clk);
    dbnc_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd2, d);
    chk("R11 master after reset", d, 0);
    chk("R11 blank after reset", blank, 0);
    chk("R3 irq idle", irq_out, 0);
    rd(2'd0, d);
    chk("R2 low status idle", d, 0);
  endtask

  task automatic t_summary();
    logic [31:0] d;
    @(negedge clk);
    pin_pend = '0; pin_pend[5] = 1'b1;
    rd(2'd0, d); chk("R1 pin5 -> bit1", d, 32'h2);
    pin_pend = '0; pin_pend[4] = 1'b1; pin_pend[7] = 1'b1;
    rd(2'd0, d); chk("R1 pins4,7 -> bit1 only", d, 32'h2);
    pin_pend = '0; pin_pend[127] = 1'b1;
    rd(2'd0, d); chk("R1 pin127 -> bit31", d, 32'h8000_0000);
    rd(2'd1, d); chk("R2 high empty", d, 0);
    pin_pend = '0; pin_pend[128] = 1'b1;
    rd(2'd1, d); chk("R2 pin128 -> high bit0", d, 32'h1);
    rd(2'd0, d); chk("R2 low empty", d, 0);
    pin_pend = '0; pin_pend[183] = 1'b1;
    rd(2'd1, d); chk("R2 pin183 -> high bit13", d, 32'h2000);
    pin_pend = '1;
    rd(2'd1, d); chk("R2 high all set, upper zero", d, 32'h3FFF);
    rd(2'd0, d); chk("R1 low all set", d, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R2 addr3 zero", d, 0);
    pin_pend = '0;
    reg_addr = 2'd0;
  endtask

  task automatic t_irq();
    @(negedge clk);
    pin_pend[0] = 1'b1;
    #1 chk("R3 irq rises on pending", irq_out, 1);
    @(negedge clk); irq_take = 1'b1;
    @(negedge clk); irq_take = 1'b0;
    #1 chk("R4 irq low after take", irq_out, 0);
    repeat (3) @(negedge clk);
    chk("R4 irq stays low while pending", irq_out, 0);
    wr_master(32'h1_0000);
    #1 chk("R5 eoi rearms with pending", irq_out, 1);
    pin_pend = '0;
    #1 chk("R3 irq low with no pending", irq_out, 0);
    @(negedge clk); pin_pend[100] = 1'b1;
    #1 chk("R5 armed line rises on new pending", irq_out, 1);
    @(negedge clk);
    irq_take = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1_0000;
    @(negedge clk);
    irq_take = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    #1 chk("R5 eoi wins over take", irq_out, 1);
    pin_pend = '0;
  endtask

  task automatic t_master();
    logic [31:0] d;
    wr_master(32'h0001_1005);
    rd(2'd2, d);
    chk("R6 master readback, eoi reads 0", d, 32'h1005);
  endtask

  task automatic t_blank();
    wr_master(32'h1005);
    dbnc_pulse();
    for (int k = 1; k <= 5; k++) begin
      chk("R7 blank during window", blank, 1);
      chk("R10 ie view hidden", pin_ie_view, 0);
      @(negedge clk);
    end
    chk("R7 blank ends after length", blank, 0);
    chk("R10 ie view restored", pin_ie_view, {NP{1'b1}});
    dbnc_pulse();
    @(negedge clk);
    @(negedge clk);
    dbnc_pulse();
    for (int k = 1; k <= 5; k++) begin
      chk("R8 restarted window", blank, 1);
      @(negedge clk);
    end
    chk("R8 restarted window ends", blank, 0);
    wr_master(32'h1000);
    dbnc_pulse();
    chk("R7 zero length gives no window", blank, 0);
    wr_master(32'h0005);
    dbnc_pulse();
    chk("R9 disabled gives no window", blank, 0);
    @(negedge clk);
    chk("R9 still no window", blank, 0);
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_summary();
    t_irq();
    t_master();
    t_blank();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule